// File: doc/BRIEF.md
# GPIO Input-Change Interrupt Generator

This block watches the pins of a group of general-purpose I/O ports and raises an active-low interrupt request whenever a pin set up as an input shows a level other than the one last captured for its port. Each port keeps a snapshot of its pins. The bus slave takes that snapshot when software reads the port's input register. The comparison is level based, not edge latched. A pin that goes back to its captured level withdraws its request without any software action.

Pins arrive asynchronously and pass through a multi-flop synchronizer before they are compared. Raw levels are compared, with no polarity inversion applied. When reset is released, the block spends a short priming phase loading every snapshot from the synchronized pins. As a result, the startup pin levels never produce an interrupt. The interrupt output is meant to drive an open-drain pad: a low value enables the pull-down.

Top module: `gpio_chg_irq`

## Requirements
- R1: During reset and after reset is released, `irq_n` is 1 and `pend` is all zero, whatever the pin levels at reset, until a pin changes afterwards.
- R2: Pin bit p belongs to port p/8, so bits 7:0 are port 0 and bits 15:8 are port 1. If an input pin (direction bit 1) changes level, that port's `pend` bit is 1 three clock edges after the change: two synchronizer edges and one compare edge.
- R3: A pin whose direction bit is 0 (output) never sets a pending flag, whatever its level does.
- R4: If an input pin returns to its captured level with no read, the port's pending flag clears three edges later.
- R5: A one-cycle pulse on `rd_strobe[k]` captures port k's current synchronized levels and clears `pend[k]` at that edge. Other ports keep their pending state.
- R6: `irq_n` is 0 exactly when at least one `pend` bit is 1, in the same cycle.
- R7: If a pin is switched from output to input while its level differs from the snapshot, the port's pending flag is set at the first edge after the direction change.
- R8: After a read has taken a new snapshot, a return of the pin to its former level counts as a change and sets the pending flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Raw pin levels, asynchronous to `clk` |
| dir_in | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_strobe | input | 2 | Per-port input-register read pulse from the bus slave |
| irq_n | output | 1 | Active-low interrupt request; low enables the open-drain pull-down |
| pend | output | 2 | Per-port pending change flags |

## Verification
The assertions assume that `dir_in` and `rd_strobe` come from logic in the `clk` domain. They also assume that a read strobe lasts one cycle. Only `pin_in` is taken to be asynchronous. The stimulus drives every input on the falling clock edge, pulses each strobe for exactly one cycle, and changes direction bits only between scenarios. Under these conditions, the rule that a pending rise must trace back to a port with at least one input pin stays valid.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  localparam int unsigned PORT_W_DEF    = 8;
  localparam int unsigned NUM_PORTS_DEF = 2;
  localparam int unsigned SYNC_DEF      = 2;

  // priming loads snapshots after reset; watching compares against them
  typedef enum logic {
    PH_PRIME = 1'b0,
    PH_WATCH = 1'b1
  } phase_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] st_d;
    if (g == 0) begin : g_first
      assign st_d = d_async;
    end else begin : g_rest
      assign st_d = st_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= '0;
      else        st_q[g] <= st_d;
    end
  end

  assign q_sync = st_q[STAGES-1];

endmodule

// File: rtl/chg_port_cell.sv
module chg_port_cell #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] lvl,
  input  logic [PW-1:0] dir_in,
  input  logic          prime,
  input  logic          rd,
  output logic          pend_nxt,
  output logic          pend_q
);

  logic [PW-1:0] snap_q;
  logic [PW-1:0] snap_d;
  logic          snap_en;
  logic [PW-1:0] diff;

  // capture on priming or on a read of this port
  assign snap_en = prime | rd;
  assign diff    = (lvl ^ snap_q) & dir_in;

  always_comb begin
    snap_d   = snap_q;
    pend_nxt = |diff;
    if (snap_en) begin
      snap_d   = lvl;
      pend_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      pend_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      pend_q <= pend_nxt;
    end
  end

endmodule

// File: rtl/chg_irq_merge.sv
module chg_irq_merge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_nxt,
  output logic         irq_n
);

  logic irq_n_d;

  assign irq_n_d = ~(|pend_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= irq_n_d;
  end

endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gpio_chg_pkg::*;
#(
  parameter int unsigned PORT_W      = PORT_W_DEF,
  parameter int unsigned NUM_PORTS   = NUM_PORTS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
  input  logic [PORT_W*NUM_PORTS-1:0]   dir_in,
  input  logic [NUM_PORTS-1:0]          rd_strobe,
  output logic                          irq_n,
  output logic [NUM_PORTS-1:0]          pend
);

  localparam int unsigned NPIN      = PORT_W * NUM_PORTS;
  localparam int unsigned PRIME_LEN = SYNC_STAGES + 1;
  localparam int unsigned CNT_W     = $clog2(PRIME_LEN + 1);
  localparam logic [CNT_W-1:0] PRIME_LAST = CNT_W'(PRIME_LEN - 1);

  logic [NPIN-1:0]      lvl_s;
  logic [NUM_PORTS-1:0] pend_nxt;
  phase_e               phase_q, phase_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 priming;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (lvl_s)
  );

  assign priming = (phase_q == PH_PRIME);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (priming) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == PRIME_LAST) phase_d = PH_WATCH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRIME;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    chg_port_cell #(.PW(PORT_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_s[p*PORT_W +: PORT_W]),
      .dir_in   (dir_in[p*PORT_W +: PORT_W]),
      .prime    (priming),
      .rd       (rd_strobe[p]),
      .pend_nxt (pend_nxt[p]),
      .pend_q   (pend[p])
    );
  end

  chg_irq_merge #(.N(NUM_PORTS)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_nxt (pend_nxt),
    .irq_n    (irq_n)
  );

endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk #(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [PORT_W*NUM_PORTS-1:0] dir_in,
  input logic [NUM_PORTS-1:0]        rd_strobe,
  input logic                        irq_n,
  input logic [NUM_PORTS-1:0]        pend
);

  // R6
  irq_tracks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == (pend == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R5
    rd_clears_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe[p] |=> !pend[p]);

    // R3
    outputs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_in[p*PORT_W +: PORT_W] == '0) |=> !pend[p]);

    // R2
    pend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[p]) |-> ($past(dir_in[p*PORT_W +: PORT_W]) != '0));
  end

endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_in    (dir_in),
  .rd_strobe (rd_strobe),
  .irq_n     (irq_n),
  .pend      (pend)
);

// File: tb/tb_gpio_chg_irq.sv
module tb_gpio_chg_irq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pin_in;
  logic [15:0] dir_in;
  logic [1:0]  rd_strobe;
  logic        irq_n;
  logic [1:0]  pend;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_chg_irq dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .dir_in    (dir_in),
    .rd_strobe (rd_strobe),
    .irq_n     (irq_n),
    .pend      (pend)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rd(logic [1:0] m);
    rd_strobe = m;
    step(1);
    rd_strobe = 2'b00;
  endtask

  // R1: startup levels never raise a request
  task automatic t_reset();
    rst_n = 1'b0; pin_in = 16'hA55A; dir_in = 16'hFFFF; rd_strobe = 2'b00;
    step(3);
    check("R1 irq_n in reset", irq_n, 1);
    check("R1 pend in reset", pend, 0);
    rst_n = 1'b1;
    step(8);
    check("R1 irq_n after reset", irq_n, 1);
    check("R1 pend after reset", pend, 0);
  endtask

  // R2, R4, R6
  task automatic t_change();
    pin_in = 16'hA55A ^ 16'h0008;
    step(2);
    check("R2 not yet after two edges", pend, 0);
    step(1);
    check("R2 port0 pending", pend, 2'b01);
    check("R6 irq low", irq_n, 0);
    pin_in = 16'hA55A;
    step(3);
    check("R4 self clear", pend, 0);
    check("R6 irq high", irq_n, 1);
    pin_in = 16'hA55A ^ 16'h1000;
    step(3);
    check("R2 port1 pending", pend, 2'b10);
    pin_in = 16'hA55A;
    step(3);
    check("R4 port1 self clear", pend, 0);
  endtask

  // R5, R8
  task automatic t_read();
    pin_in = 16'hA55A ^ 16'h0108;
    step(3);
    check("R5 both pending", pend, 2'b11);
    pulse_rd(2'b01);
    check("R5 read port0 clears it only", pend, 2'b10);
    check("R6 irq still low", irq_n, 0);
    step(2);
    check("R5 port1 keeps pending", pend, 2'b10);
    pulse_rd(2'b10);
    check("R5 read port1", pend, 2'b00);
    check("R6 irq released", irq_n, 1);
    pin_in = 16'hA55A;
    step(3);
    check("R8 return after read re-raises", pend, 2'b11);
    pulse_rd(2'b11);
    check("R5 read both", pend, 2'b00);
  endtask

  // R3
  task automatic t_outputs();
    dir_in = 16'hFF00;
    pin_in = 16'hA55A ^ 16'h00FF;
    step(4);
    check("R3 port0 outputs ignored", pend, 0);
    check("R3 irq high", irq_n, 1);
    dir_in = 16'hF0FF;
    pin_in = 16'hA55A ^ 16'h0FFF;
    dir_in = 16'hF000;
    step(4);
    check("R3 mixed port1 outputs ignored", pend, 0);
  endtask

  // R7
  task automatic t_dir_switch();
    dir_in = 16'hFFFF;
    step(1);
    check("R7 switch to input raises", pend, 2'b11);
    check("R7 irq low", irq_n, 0);
    pin_in = 16'hA55A;
    step(3);
    check("R4 restore clears", pend, 0);
  endtask

  initial begin
    t_reset();
    t_change();
    t_read();
    t_outputs();
    t_dir_switch();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule